// File: doc/BRIEF.md
# Write Leveling Strobe Delay Search

This block is the controller-side sequencer that aligns the write data strobe with the memory clock. On a start request it asks the command path to issue a mode-register write that puts the memory into leveling mode. It then tries strobe delay codes one after another, starting at zero. For each code it fires one strobe pulse, waits a programmable number of settle cycles, and samples the single feedback bit that the memory returns.

The memory returns 0 while the strobe arrives too early. It returns 1 once the added delay has moved the strobe edge into the window of 0.75 to 1.25 clock periods. The block searches for the first rising change of the feedback. To reject noise, a 1 counts only when the next trial also reads 1. The code of the first 1 in such a pair is kept. The block then asks for a second mode-register write to leave leveling mode and reports completion. If the largest code is tried without a confirmed change, it reports completion with an error flag.

The delay line, the pad sampling and all other memory commands are outside this block.

Top module: `wlvl_search`

## Requirements
- R1: After synchronous reset, `mr_req`, `dqs_pulse`, `done`, `err` and `busy` are 0 and `dly_code` is 0.
- R2: A `start` in idle raises `mr_req` with `mr_enter`=1. Both stay unchanged until `mr_ack` is sampled high, and no `dqs_pulse` occurs before that acknowledge.
- R3: After the entry acknowledge the trial code starts at 0. Each trial produces exactly one single-cycle `dqs_pulse`, and `dly_code` during the n-th pulse (counting from 0) equals n.
- R4: Successive strobe pulses are exactly `settle_cyc`+3 cycles apart. `fb` is sampled only in the cycle that lies `settle_cyc`+2 cycles after the pulse cycle.
- R5: Feedback samples of 1 taken before any sample of 0 are ignored and cannot complete the search.
- R6: After a 0 has been seen, two consecutive samples of 1 complete the search with `dly_code` equal to the code of the first of those two samples. A lone 1 that is followed by 0 is discarded.
- R7: If the largest code (all ones) has been sampled without a confirmed change, the block exits with `err`=1 during `done`, and `dly_code` stays at the largest code.
- R8: On completion, `mr_req` is raised with `mr_enter`=0 until acknowledged. Then `done` is high for exactly one cycle and `err` is valid only in that cycle. `dly_code` then holds its result while idle.
- R9: `start` is ignored while `busy` is high. The running search is unaffected, and nothing restarts after `done`.
- R10: When the confirming 1 is sampled at the largest code, the search succeeds: `err`=0 and `dly_code` = largest code − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| settle_cyc | input | SETTLE_W | Number of extra wait cycles between a strobe pulse and the feedback sample |
| mr_ack | input | 1 | Command path has issued the requested mode-register write |
| fb | input | 1 | Leveling feedback bit returned on the data lines |
| mr_req | output | 1 | Request for a mode-register write |
| mr_enter | output | 1 | 1: enter leveling mode, 0: leave it; valid with `mr_req` |
| dqs_pulse | output | 1 | One-cycle strobe pulse for the current trial |
| dly_code | output | CODE_W | Strobe delay code: the current trial, or the result after completion |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No transition found; valid only with `done` |

## Verification
Two events can fall on the same sample: the confirming second 1 of a rising change, and the arrival at the largest code, which by itself ends the search with an error. The bench provokes this by placing the feedback change exactly one code below the largest. It expects success at that code with no error, and it also checks the neighbouring profiles where the change sits at the largest code or never occurs. The bench holds `fb` at the wrong value in every cycle except the exact sample cycle, so a settle counter that is off by one shows up as a wrong result.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [2:0] {
        WL_IDLE,
        WL_ENTER,
        WL_PULSE,
        WL_WAIT,
        WL_SAMPLE,
        WL_EXIT,
        WL_DONE
    } wl_state_e;

    typedef struct packed {
        logic valid;
        logic enter;
    } wl_mr_t;

    typedef struct packed {
        logic confirm;
        logic arm;
    } wl_verdict_t;

    function automatic logic state_busy(wl_state_e s);
        return s != WL_IDLE;
    endfunction

endpackage

// File: rtl/wlvl_settle_timer.sv
module wlvl_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wlvl_edge_filter.sv
module wlvl_edge_filter
    import wlvl_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int CONFIRM_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample_en,
    input  logic              fb,
    input  logic [CODE_W-1:0] code,
    output wl_verdict_t       verdict,
    output logic [CODE_W-1:0] cand_code
);
    localparam int OW = $clog2(CONFIRM_N + 1);
    localparam logic [OW-1:0] LAST_ONE = OW'(CONFIRM_N - 1);

    logic              seen_low_q;
    logic [OW-1:0]     ones_q;
    logic [CODE_W-1:0] cand_q;

    always_comb begin
        verdict.arm     = sample_en && fb && seen_low_q;
        verdict.confirm = verdict.arm && (ones_q == LAST_ONE);
        cand_code       = (ones_q == '0) ? code : cand_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_low_q <= 1'b0;
            ones_q     <= '0;
            cand_q     <= '0;
        end else if (sample_en) begin
            if (!fb) begin
                seen_low_q <= 1'b1;
                ones_q     <= '0;
            end else if (verdict.arm && !verdict.confirm) begin
                if (ones_q == '0) begin
                    cand_q <= code;
                end
                ones_q <= ones_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
    import wlvl_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mr_ack,
    input  logic              timer_expired,
    input  wl_verdict_t       verdict,
    input  logic [CODE_W-1:0] cand_code,
    output wl_mr_t            mr,
    output logic              timer_load,
    output logic              timer_run,
    output logic              sample_en,
    output logic              filter_clear,
    output logic              dqs_pulse,
    output logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    wl_state_e         state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic              fail_q, fail_d;

    always_comb begin
        state_d      = state_q;
        code_d       = code_q;
        fail_d       = fail_q;
        mr           = '0;
        timer_load   = 1'b0;
        timer_run    = 1'b0;
        sample_en    = 1'b0;
        filter_clear = 1'b0;
        dqs_pulse    = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            WL_IDLE: begin
                if (start) begin
                    filter_clear = 1'b1;
                    fail_d       = 1'b0;
                    state_d      = WL_ENTER;
                end
            end
            WL_ENTER: begin
                mr.valid = 1'b1;
                mr.enter = 1'b1;
                if (mr_ack) begin
                    code_d  = '0;
                    state_d = WL_PULSE;
                end
            end
            WL_PULSE: begin
                dqs_pulse  = 1'b1;
                timer_load = 1'b1;
                state_d    = WL_WAIT;
            end
            WL_WAIT: begin
                timer_run = 1'b1;
                if (timer_expired) begin
                    state_d = WL_SAMPLE;
                end
            end
            WL_SAMPLE: begin
                sample_en = 1'b1;
                if (verdict.confirm) begin
                    code_d  = cand_code;
                    fail_d  = 1'b0;
                    state_d = WL_EXIT;
                end else if (code_q == CODE_MAX) begin
                    fail_d  = 1'b1;
                    state_d = WL_EXIT;
                end else begin
                    code_d  = code_q + 1'b1;
                    state_d = WL_PULSE;
                end
            end
            WL_EXIT: begin
                mr.valid = 1'b1;
                mr.enter = 1'b0;
                if (mr_ack) begin
                    state_d = WL_DONE;
                end
            end
            WL_DONE: begin
                done    = 1'b1;
                state_d = WL_IDLE;
            end
            default: state_d = WL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WL_IDLE;
            code_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            fail_q  <= fail_d;
        end
    end

    assign code = code_q;
    assign busy = state_busy(state_q);
    assign err  = done && fail_q;
endmodule

// File: rtl/wlvl_search.sv
module wlvl_search
    import wlvl_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int SETTLE_W  = 8,
    parameter int CONFIRM_N = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cyc,
    input  logic                mr_ack,
    input  logic                fb,
    output logic                mr_req,
    output logic                mr_enter,
    output logic                dqs_pulse,
    output logic [CODE_W-1:0]   dly_code,
    output logic                busy,
    output logic                done,
    output logic                err
);
    wl_mr_t            mr;
    wl_verdict_t       verdict;
    logic [CODE_W-1:0] cand_code;
    logic              timer_load, timer_run, timer_expired;
    logic              sample_en, filter_clear;

    wlvl_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (settle_cyc),
        .run      (timer_run),
        .expired  (timer_expired)
    );

    wlvl_edge_filter #(.CODE_W(CODE_W), .CONFIRM_N(CONFIRM_N)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .clear     (filter_clear),
        .sample_en (sample_en),
        .fb        (fb),
        .code      (dly_code),
        .verdict   (verdict),
        .cand_code (cand_code)
    );

    wlvl_seq #(.CODE_W(CODE_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .mr_ack        (mr_ack),
        .timer_expired (timer_expired),
        .verdict       (verdict),
        .cand_code     (cand_code),
        .mr            (mr),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .sample_en     (sample_en),
        .filter_clear  (filter_clear),
        .dqs_pulse     (dqs_pulse),
        .code          (dly_code),
        .busy          (busy),
        .done          (done),
        .err           (err)
    );

    assign mr_req   = mr.valid;
    assign mr_enter = mr.enter;
endmodule

// File: rtl/wlvl_search_chk.sv
module wlvl_search_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mr_ack,
    input logic              mr_req,
    input logic              mr_enter,
    input logic              dqs_pulse,
    input logic [CODE_W-1:0] dly_code,
    input logic              busy,
    input logic              done,
    input logic              err
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        mr_req && !mr_ack |=> mr_req && $stable(mr_enter));

    a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
        dqs_pulse |=> !dqs_pulse);

    a_r3_no_pulse_with_req: assert property (@(posedge clk) disable iff (rst)
        !(dqs_pulse && mr_req));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r8_idle_code_held: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(dly_code));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && !done |=> busy);
endmodule

bind wlvl_search wlvl_search_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mr_ack    (mr_ack),
    .mr_req    (mr_req),
    .mr_enter  (mr_enter),
    .dqs_pulse (dqs_pulse),
    .dly_code  (dly_code),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/wlvl_search_tb.sv
module wlvl_search_tb;
    localparam int CW   = 6;
    localparam int SW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [SW-1:0] settle_cyc = '0;
    logic          mr_ack = 1'b0;
    logic          fb = 1'b0;
    logic          mr_req, mr_enter, dqs_pulse, busy, done, err;
    logic [CW-1:0] dly_code;

    int n_chk = 0;
    int n_fail = 0;
    int gcyc = 0;
    int p_i, p_g, p_t;

    always #2 clk = ~clk;

    wlvl_search #(.CODE_W(CW), .SETTLE_W(SW), .CONFIRM_N(2)) u_dut (
        .clk(clk), .rst(rst), .start(start), .settle_cyc(settle_cyc),
        .mr_ack(mr_ack), .fb(fb), .mr_req(mr_req), .mr_enter(mr_enter),
        .dqs_pulse(dqs_pulse), .dly_code(dly_code), .busy(busy),
        .done(done), .err(err)
    );

    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit fb_true(input int c);
        if (c < p_i) return 1'b1;
        if (c == p_g) return 1'b1;
        if (c >= p_t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model(output int c, output bit e, output int n);
        bit s0;
        int cand;
        s0 = 1'b0;
        cand = -1;
        e = 1'b1;
        c = MAXC;
        n = MAXC + 1;
        for (int x = 0; x <= MAXC; x++) begin
            bit v;
            v = fb_true(x);
            if (!v) begin
                s0 = 1'b1;
                cand = -1;
            end else if (s0) begin
                if (cand < 0) begin
                    cand = x;
                end else begin
                    c = cand;
                    e = 1'b0;
                    n = x + 1;
                    return;
                end
            end
        end
    endfunction

    task automatic run_case(input int i0, input int g0, input int t0, input int st,
                            input int ad, input bit poke, input string tag);
        int exp_code, exp_np, k, np, wait_ack, last_p, cyc, pcode, held;
        bit exp_err, enter_done, exit_done, fin;
        p_i = i0; p_g = g0; p_t = t0;
        model(exp_code, exp_err, exp_np);
        @(negedge clk);
        settle_cyc = SW'(st);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = -1; np = 0; wait_ack = 0; last_p = -1; cyc = 0; pcode = 0;
        enter_done = 1'b0; exit_done = 1'b0; fin = 1'b0;
        while (!fin && cyc < 5000) begin
            cyc++;
            mr_ack = 1'b0;
            start = 1'b0;
            if (done) begin
                fin = 1'b1;
                chk(err == exp_err, exp_err ? "R7" : tag, int'(err), int'(exp_err));
                chk(int'(dly_code) == exp_code, tag, int'(dly_code), exp_code);
                chk(np == exp_np, "R3 trial count", np, exp_np);
                chk(exit_done, "R8 exit before done", int'(exit_done), 1);
            end else begin
                if (mr_req) begin
                    chk(mr_enter == !enter_done, enter_done ? "R8 mr_enter" : "R2 mr_enter",
                        int'(mr_enter), int'(!enter_done));
                    if (wait_ack == ad) begin
                        mr_ack = 1'b1;
                        wait_ack = 0;
                        if (!enter_done) enter_done = 1'b1;
                        else exit_done = 1'b1;
                    end else begin
                        wait_ack++;
                    end
                end
                if (dqs_pulse) begin
                    chk(enter_done, "R2 pulse after ack", int'(enter_done), 1);
                    chk(int'(dly_code) == np, "R3 code step", int'(dly_code), np);
                    if (last_p >= 0) chk(cyc - last_p == st + 3, "R4 spacing", cyc - last_p, st + 3);
                    last_p = cyc;
                    pcode = int'(dly_code);
                    np++;
                    k = 0;
                end else if (k >= 0) begin
                    k++;
                end
                fb = (k == st + 2) ? fb_true(pcode) : !fb_true(pcode);
                if (poke && np == 2 && k == 1) start = 1'b1;
            end
            @(negedge clk);
        end
        mr_ack = 1'b0;
        start = 1'b0;
        chk(fin, "R8 completion", int'(fin), 1);
        chk(!done, "R8 done width", int'(done), 0);
        held = int'(dly_code);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(!busy && !mr_req, "R9 no restart", int'(busy || mr_req), 0);
            chk(int'(dly_code) == held, "R8 result held", int'(dly_code), held);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mr_req && !dqs_pulse && !done && !err && !busy, "R1 outputs",
            int'({mr_req, dqs_pulse, done, err, busy}), 0);
        chk(dly_code == '0, "R1 code", int'(dly_code), 0);

        run_case(0, -1, 10, 2, 0, 1'b1, "R6 plain");
        run_case(3, -1, 7, 0, 1, 1'b0, "R5 leading ones");
        run_case(0, 4, 9, 1, 2, 1'b1, "R6 lone one");
        run_case(0, -1, MAXC + 1, 0, 0, 1'b0, "R7 never");
        run_case(0, -1, MAXC, 1, 1, 1'b0, "R7 at max");
        run_case(0, -1, MAXC - 1, 3, 0, 1'b0, "R10 confirm at max");
        run_case(MAXC + 1, -1, MAXC + 1, 0, 0, 1'b0, "R5 all ones");
        run_case(2, 5, 6, 4, 3, 1'b1, "R6 lone then change");

        for (int r = 0; r < 12; r++) begin
            int i0, t0, g0, st, ad;
            i0 = int'($urandom_range(0, 4));
            t0 = int'($urandom_range(i0 + 2, MAXC + 1));
            g0 = -1;
            if (t0 - i0 >= 4 && $urandom_range(0, 1) == 1)
                g0 = int'($urandom_range(i0 + 1, t0 - 2));
            st = int'($urandom_range(0, 5));
            ad = int'($urandom_range(0, 3));
            run_case(i0, g0, t0, st, ad, r[0], "R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule